// File: doc/BRIEF.md
# Multi-Input Wake-Up Interrupt Unit

The unit watches a bank of asynchronous wake-up lines, arranged in groups of eight, and turns activity on them into one interrupt request per group. Every line passes through a synchroniser. It can then be configured to detect one of the following:

- a level, either active high or active low;
- an edge, either rising, falling, or both through an any-edge override.

A detected event latches into a per-line pending bit. That bit stays set until software clears it by writing a one to the clear register. A per-line interrupt enable masks which pending bits reach the group's request output.

Software reaches each group through a small register bus. Each group has seven registers, selected by the low three address bits. The bits above them select the group. Reads return data one cycle after the read strobe. A per-line input-enable gate stops a line from producing events. While a line is gated, the detector's record of its last level is frozen. Opening the gate on a line whose level has moved therefore raises one event at once, and software is expected to clear it.

Top module: `wkup_unit`

## Requirements
- R1: After reset every configuration register, every pending bit, `irq` and `bus_rdata` are 0.
- R2: With mode bit 1 and polarity bit 0, pending is set on every cycle the synchronised line is high. A clear while the level persists leaves the bit set.
- R3: With mode bit 1 and polarity bit 1, pending is set on every cycle the synchronised line is low.
- R4: With mode bit 0, polarity 0 and any-edge 0, only a rising transition sets pending. A falling one does not.
- R5: With mode bit 0, polarity 1 and any-edge 0, only a falling transition sets pending. This covers a serial start bit.
- R6: With mode bit 0 and any-edge 1, both transitions set pending, whatever the polarity bit holds.
- R7: Writing the clear register (select 6) clears each pending bit whose data bit is 1. Data bits of 0 leave their pending bits alone. Writes to the pending register (select 5) change nothing.
- R8: `irq[g]` is 1 exactly one cycle after any pending bit of group g is set while its interrupt-enable bit is 1.
- R9: A line whose input-enable bit is 0 never sets pending. Enabling a line whose level differs from the last level seen while it was enabled sets pending in edge mode.
- R10: Groups are independent. Each has its own registers, and activity on one group's lines never changes another group's pending bits or `irq`.
- R11: A line change driven before clock edge k sets pending at edge k+2, through a two-flop synchroniser.
- R12: Address = {group, select}. The selects are mode 0, polarity 1, any-edge 2, input-enable 3, interrupt-enable 4, pending 5 and clear 6. Select 6 and select 7 read 0. `bus_rdata` loads on a read strobe one cycle later and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wake_in | input | NUM_GROUPS*LINES | Asynchronous wake-up lines, line l of group g at g*LINES+l |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | GRP_W+3 | {group, register select} |
| bus_wdata | input | LINES | Write data, one bit per line |
| bus_rdata | output | LINES | Registered read data |
| irq | output | NUM_GROUPS | Per-group interrupt request |

## Verification
The assertions assume the bus strobes and address are free of X once reset is released. They also assume a pending bit drops only through a clear write and rises only on a line whose input gate was open on the previous cycle. The bench drives every input at the falling clock edge, so each line is stable across the capturing edge, and its reference model sees the same synchronised samples as the design. Line changes are spaced by several cycles, so each transition reaches the detector as one clean edge.

// File: rtl/wkup_pkg.sv
package wkup_pkg;

  // Register select field (low three address bits); the bus decode depends on it.
  typedef enum logic [2:0] {
    SEL_MODE = 3'd0,
    SEL_POL  = 3'd1,
    SEL_ANY  = 3'd2,
    SEL_INEN = 3'd3,
    SEL_IEN  = 3'd4,
    SEL_PEND = 3'd5,
    SEL_PCLR = 3'd6,
    SEL_RSVD = 3'd7
  } reg_sel_e;

  localparam int SEL_W = 3;

endpackage

// File: rtl/wkup_sync.sv
module wkup_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/wkup_line.sv
module wkup_line (
  input  logic clk,
  input  logic rst,
  input  logic smp,    // synchronised line level
  input  logic mode,   // 1 level, 0 edge
  input  logic pol,    // 0 high/rising, 1 low/falling
  input  logic any,    // edge mode: both transitions
  input  logic inen,   // input gate
  input  logic clr,    // write-one clear strobe
  output logic pend
);

  logic hist_q;
  logic rise, fall, evt;

  // History follows the line only while the gate is open.
  always_ff @(posedge clk) begin
    if (rst)       hist_q <= 1'b0;
    else if (inen) hist_q <= smp;
  end

  always_comb begin
    rise = smp & ~hist_q;
    fall = ~smp & hist_q;
    if (!inen)     evt = 1'b0;
    else if (mode) evt = pol ? ~smp : smp;
    else if (any)  evt = rise | fall;
    else           evt = pol ? fall : rise;
  end

  // A new event outranks a simultaneous clear, so no event is lost.
  always_ff @(posedge clk) begin
    if (rst) pend <= 1'b0;
    else     pend <= (pend & ~clr) | evt;
  end

endmodule

// File: rtl/wkup_group.sv
module wkup_group
  import wkup_pkg::*;
#(
  parameter int LINES = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] smp,
  input  logic             wr_hit,
  input  reg_sel_e         wsel,
  input  logic [LINES-1:0] wdata,
  input  reg_sel_e         rsel,
  output logic [LINES-1:0] rd_val,
  output logic [LINES-1:0] pend_o,
  output logic [LINES-1:0] inen_o,
  output logic [LINES-1:0] ien_o,
  output logic             irq_o
);

  logic [LINES-1:0] mode_q, pol_q, any_q, inen_q, ien_q;
  logic [LINES-1:0] clr_vec;
  logic [LINES-1:0] pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      pol_q  <= '0;
      any_q  <= '0;
      inen_q <= '0;
      ien_q  <= '0;
    end else if (wr_hit) begin
      case (wsel)
        SEL_MODE: mode_q <= wdata;
        SEL_POL:  pol_q  <= wdata;
        SEL_ANY:  any_q  <= wdata;
        SEL_INEN: inen_q <= wdata;
        SEL_IEN:  ien_q  <= wdata;
        default:  ;
      endcase
    end
  end

  assign clr_vec = (wr_hit && wsel == SEL_PCLR) ? wdata : '0;

  for (genvar l = 0; l < LINES; l++) begin : g_line
    wkup_line u_line (
      .clk  (clk),
      .rst  (rst),
      .smp  (smp[l]),
      .mode (mode_q[l]),
      .pol  (pol_q[l]),
      .any  (any_q[l]),
      .inen (inen_q[l]),
      .clr  (clr_vec[l]),
      .pend (pend_q[l])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |(pend_q & ien_q);
  end

  always_comb begin
    case (rsel)
      SEL_MODE: rd_val = mode_q;
      SEL_POL:  rd_val = pol_q;
      SEL_ANY:  rd_val = any_q;
      SEL_INEN: rd_val = inen_q;
      SEL_IEN:  rd_val = ien_q;
      SEL_PEND: rd_val = pend_q;
      default:  rd_val = '0;
    endcase
  end

  assign pend_o = pend_q;
  assign inen_o = inen_q;
  assign ien_o  = ien_q;

endmodule

// File: rtl/wkup_unit.sv
module wkup_unit
  import wkup_pkg::*;
#(
  parameter  int NUM_GROUPS  = 4,
  parameter  int LINES       = 8,
  parameter  int SYNC_STAGES = 2,
  localparam int NUM_LINES   = NUM_GROUPS * LINES,
  localparam int GRP_W       = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
  localparam int ADDR_W      = GRP_W + SEL_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_LINES-1:0]  wake_in,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [LINES-1:0]      bus_wdata,
  output logic [LINES-1:0]      bus_rdata,
  output logic [NUM_GROUPS-1:0] irq
);

  logic [NUM_LINES-1:0]  smp_vec;
  logic [NUM_LINES-1:0]  pend_vec, inen_vec, ien_vec;
  logic [GRP_W-1:0]      addr_grp;
  reg_sel_e              addr_sel;
  logic [LINES-1:0]      grp_rd [NUM_GROUPS];
  logic [LINES-1:0]      rd_mux;

  assign addr_grp = bus_addr[ADDR_W-1:SEL_W];
  assign addr_sel = reg_sel_e'(bus_addr[SEL_W-1:0]);

  wkup_sync #(
    .WIDTH  (NUM_LINES),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (wake_in),
    .q   (smp_vec)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    logic wr_hit;
    assign wr_hit = bus_wr && (addr_grp == GRP_W'(g));

    wkup_group #(
      .LINES (LINES)
    ) u_group (
      .clk    (clk),
      .rst    (rst),
      .smp    (smp_vec[g*LINES +: LINES]),
      .wr_hit (wr_hit),
      .wsel   (addr_sel),
      .wdata  (bus_wdata),
      .rsel   (addr_sel),
      .rd_val (grp_rd[g]),
      .pend_o (pend_vec[g*LINES +: LINES]),
      .inen_o (inen_vec[g*LINES +: LINES]),
      .ien_o  (ien_vec[g*LINES +: LINES]),
      .irq_o  (irq[g])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (addr_grp == GRP_W'(g)) rd_mux = grp_rd[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

endmodule

// File: rtl/wkup_unit_chk.sv
module wkup_unit_chk #(
  parameter  int NUM_GROUPS = 4,
  parameter  int LINES      = 8,
  localparam int NUM_LINES  = NUM_GROUPS * LINES,
  localparam int GRP_W      = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
  localparam int ADDR_W     = GRP_W + 3
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  bus_wr,
  input logic                  bus_rd,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic [LINES-1:0]      bus_wdata,
  input logic [LINES-1:0]      bus_rdata,
  input logic [NUM_GROUPS-1:0] irq,
  input logic [NUM_LINES-1:0]  pend_vec,
  input logic [NUM_LINES-1:0]  inen_vec,
  input logic [NUM_LINES-1:0]  ien_vec
);

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (irq == '0 && bus_rdata == '0 && pend_vec == '0));

  // R12
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_rd) |-> $stable(bus_rdata));

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_gc
    // R8
    irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(|ien_vec[g*LINES +: LINES]) |-> !irq[g]);

    for (genvar l = 0; l < LINES; l++) begin : g_lc
      // R9
      gated_no_pend_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_vec[g*LINES+l]) |-> $past(inen_vec[g*LINES+l]));

      // R7
      clear_only_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(pend_vec[g*LINES+l]) |->
          $past(bus_wr && bus_addr == {GRP_W'(g), 3'd6} && bus_wdata[l]));
    end
  end

endmodule

bind wkup_unit wkup_unit_chk #(
  .NUM_GROUPS (NUM_GROUPS),
  .LINES      (LINES)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq       (irq),
  .pend_vec  (pend_vec),
  .inen_vec  (inen_vec),
  .ien_vec   (ien_vec)
);

// File: tb/wkup_unit_test.sv
module wkup_unit_test;

  localparam int NG = 4;
  localparam int L  = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NG*L-1:0] wake_in = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [4:0]    bus_addr = '0;
  logic [7:0]    bus_wdata = '0;
  logic [7:0]    bus_rdata;
  logic [NG-1:0] irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  wkup_unit uut (
    .clk       (clk),
    .rst       (rst),
    .wake_in   (wake_in),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_mode[NG], m_pol[NG], m_any[NG], m_inen[NG], m_ien[NG], m_pend[NG];
  logic [NG*L-1:0] m_s1, m_s2, m_hist;
  logic [NG-1:0] m_irq;
  logic [7:0] m_rdata;

  always @(posedge clk) begin : mdl
    int wg, ws, idx;
    logic s, h, ev, cl;
    if (rst) begin
      for (int g = 0; g < NG; g++) begin
        m_mode[g] = 0; m_pol[g] = 0; m_any[g] = 0;
        m_inen[g] = 0; m_ien[g] = 0; m_pend[g] = 0;
      end
      m_s1 = 0; m_s2 = 0; m_hist = 0; m_irq = 0; m_rdata = 0;
    end else begin
      wg = int'(bus_addr[4:3]);
      ws = int'(bus_addr[2:0]);
      if (bus_rd) begin
        case (ws)
          0: m_rdata = m_mode[wg];
          1: m_rdata = m_pol[wg];
          2: m_rdata = m_any[wg];
          3: m_rdata = m_inen[wg];
          4: m_rdata = m_ien[wg];
          5: m_rdata = m_pend[wg];
          default: m_rdata = 0;
        endcase
      end
      for (int g = 0; g < NG; g++) m_irq[g] = |(m_pend[g] & m_ien[g]);
      for (int g = 0; g < NG; g++) begin
        for (int l = 0; l < L; l++) begin
          idx = g * L + l;
          s = m_s2[idx];
          h = m_hist[idx];
          ev = 0;
          if (m_inen[g][l]) begin
            if (m_mode[g][l])     ev = m_pol[g][l] ? !s : s;
            else if (m_any[g][l]) ev = (s != h);
            else if (m_pol[g][l]) ev = h && !s;
            else                  ev = !h && s;
            m_hist[idx] = s;
          end
          cl = bus_wr && wg == g && ws == 6 && bus_wdata[l];
          m_pend[g][l] = (m_pend[g][l] && !cl) || ev;
        end
      end
      m_s2 = m_s1;
      m_s1 = wake_in;
      if (bus_wr) begin
        case (ws)
          0: m_mode[wg] = bus_wdata;
          1: m_pol[wg]  = bus_wdata;
          2: m_any[wg]  = bus_wdata;
          3: m_inen[wg] = bus_wdata;
          4: m_ien[wg]  = bus_wdata;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Every-clock comparison against the model (R8 irq, R12 read data)
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R8 model irq", 32'(irq), 32'(m_irq));
      chk("R12 model rdata", 32'(bus_rdata), 32'(m_rdata));
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic wr(input int g, input int sel, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = {2'(g), 3'(sel)}; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int g, input int sel, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = {2'(g), 3'(sel)};
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pin(input int idx, input logic v);
    @(negedge clk);
    wake_in[idx] = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // ---------------- directed sequence ----------------
  initial begin : main
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    for (int s = 0; s < 7; s++) begin
      rd(0, s, v); chk("R1 group0 reg", 32'(v), 0);
      rd(3, s, v); chk("R1 group3 reg", 32'(v), 0);
    end
    chk("R1 irq", 32'(irq), 0);

    // R2 level high, line 0 of group 0
    wr(0, 0, 8'h01); wr(0, 3, 8'h01); wr(0, 4, 8'h01);
    pin(0, 1'b1); idle(4);
    rd(0, 5, v); chk("R2 level high sets", 32'(v), 32'h01);
    chk("R8 irq follows enabled pending", 32'(irq[0]), 1);
    wr(0, 6, 8'h01);
    rd(0, 5, v); chk("R2 clear while level held", 32'(v), 32'h01);
    pin(0, 1'b0); idle(3);
    wr(0, 6, 8'h01);
    rd(0, 5, v); chk("R2 clear after level gone", 32'(v), 0);
    chk("R8 irq drops", 32'(irq[0]), 0);

    // R3 level low, line 1 of group 0 (interrupt-masked)
    wr(0, 0, 8'h03); wr(0, 1, 8'h02); wr(0, 3, 8'h03);
    idle(3);
    rd(0, 5, v); chk("R3 level low sets", 32'(v), 32'h02);
    chk("R8 masked line gives no irq", 32'(irq[0]), 0);
    pin(1, 1'b1); idle(3);
    wr(0, 6, 8'h02);
    rd(0, 5, v); chk("R3 high level leaves clear", 32'(v), 0);

    // R4 rising edge, line 2 of group 1
    wr(1, 3, 8'h04); wr(1, 4, 8'h04);
    pin(10, 1'b1); idle(4);
    rd(1, 5, v); chk("R4 rising sets", 32'(v), 32'h04);
    chk("R10 group1 irq", 32'(irq[1]), 1);
    chk("R10 group0 untouched", 32'(irq[0]), 0);
    wr(1, 6, 8'h04);
    pin(10, 1'b0); idle(4);
    rd(1, 5, v); chk("R4 falling ignored", 32'(v), 0);
    chk("R8 irq low after clear", 32'(irq[1]), 0);

    // R5 falling edge, line 3 of group 1
    wr(1, 1, 8'h08); wr(1, 3, 8'h0C);
    pin(11, 1'b1); idle(4);
    rd(1, 5, v); chk("R5 rising ignored", 32'(v), 0);
    pin(11, 1'b0); idle(4);
    rd(1, 5, v); chk("R5 falling sets", 32'(v), 32'h08);

    // R6 any edge, line 4 of group 1 with polarity 1
    wr(1, 2, 8'h10); wr(1, 1, 8'h18); wr(1, 3, 8'h1C);
    pin(12, 1'b1); idle(4);
    rd(1, 5, v); chk("R6 rising with any-edge", 32'(v), 32'h18);
    wr(1, 6, 8'h10);
    rd(1, 5, v); chk("R7 single-bit clear", 32'(v), 32'h08);
    pin(12, 1'b0); idle(4);
    rd(1, 5, v); chk("R6 falling with any-edge", 32'(v), 32'h18);

    // R7 clear semantics
    wr(1, 5, 8'hFF);
    rd(1, 5, v); chk("R7 pending write ignored", 32'(v), 32'h18);
    wr(1, 6, 8'h00);
    rd(1, 5, v); chk("R7 zero clear no effect", 32'(v), 32'h18);
    wr(1, 6, 8'h10);
    rd(1, 5, v); chk("R7 clear bit4 only", 32'(v), 32'h08);
    wr(1, 6, 8'h08);
    rd(1, 5, v); chk("R7 clear bit3", 32'(v), 0);

    // R9 input gate, line 0 of group 2 rising edge
    wr(2, 4, 8'h01);
    pin(16, 1'b1); idle(4);
    rd(2, 5, v); chk("R9 gated line no pending", 32'(v), 0);
    chk("R9 gated line no irq", 32'(irq[2]), 0);
    wr(2, 3, 8'h01); idle(3);
    rd(2, 5, v); chk("R9 enabling sets pending", 32'(v), 32'h01);
    chk("R8 group2 irq", 32'(irq[2]), 1);
    chk("R10 group1 quiet", 32'(irq[1]), 0);

    // R11 synchroniser latency, line 0 of group 3 level high
    wr(3, 0, 8'h01); wr(3, 3, 8'h01);
    pin(24, 1'b1);
    rd(3, 5, v); chk("R11 not yet pending", 32'(v), 0);
    rd(3, 5, v); chk("R11 pending at edge k+2", 32'(v), 32'h01);

    // R12 map and reserved selects
    rd(1, 7, v); chk("R12 reserved reads 0", 32'(v), 0);
    rd(2, 6, v); chk("R12 clear reads 0", 32'(v), 0);
    rd(1, 1, v); chk("R12 polarity readback", 32'(v), 32'h18);
    rd(1, 2, v); chk("R12 any-edge readback", 32'(v), 32'h10);
    rd(3, 0, v); chk("R12 mode readback", 32'(v), 32'h01);

    idle(4);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule